// File: doc/BRIEF.md
# Clock-Control Register Bank

This block is the software-visible configuration store of a clock control unit. It decodes a byte offset within a 4 KB window into a word index and keeps the settings that the clock generators read. These are a mode word, two post-divider words, two PLL control words and a set of clock-gate words. There are also two power-management words: one that software can read and one that exists only on the parallel outputs. Every stored word is presented on its own output bus, so the clock logic sees a new setting one cycle after the write that sets it.

Accesses use a simple request/response handshake. In the idle state `ST_IDLE` the block raises `req_ready`. A request accepted there (transition `accept`) moves the machine to `ST_RESP`. In `ST_RESP` the block drives `rsp_valid` for one cycle with the read data and an error flag, and then returns to idle (transition `respond_done`). A write takes effect at the acceptance edge.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the stored words are: mode 0x074b0b7d, divider0 0xff870b48, divider1 0x49fcfe7f, PLL0 0x04001800, PLL1 0x04043001, every gate word 0xffffffff, pm0 0x80209828, pm1 0x00aa0000. These values are readable where mapped and visible on the cfg outputs.
- R2: The word index is `req_addr >> 2`. The mapped indices are: 0 mode, 1 divider0, 2 divider1, 4 PLL0, 6 PLL1, 8 up to 8+N_GATE-1 the gate words, 18 a constant, and 23 pm0. A write to one index leaves every other word unchanged.
- R3: A write to the mode word stores `(wdata & 0x3b6fdfff) | 0x20`, so bit 5 reads as one after any mode write.
- R4: A write to divider0 stores `wdata & 0xff9f3fff`. A write to either PLL word stores `wdata & 0xbfff3fff`.
- R5: Writes to divider1 and to the gate words store the full 32-bit word.
- R6: Index 18 reads as 0x00004040 and index 23 reads as pm0. Both are read-only: a write to them stores nothing and sets `rsp_err`.
- R7: An access to an unmapped index returns `rsp_rdata` 0 with `rsp_err` 1, and a write there changes no word. Every response with `rsp_err` set carries zero data. A write response always carries zero data.
- R8: An access with `req_addr[1:0]` non-zero is rejected. It gives `rsp_err` 1 and data 0, and changes no word.
- R9: `req_ready` is 1 in `ST_IDLE`. An accepted request is answered in the next cycle with `rsp_valid` 1 and `req_ready` 0, and the machine then returns to idle.
- R10: pm1 keeps its reset value. Index 24 and every other offset act as unmapped, so no bus access can read or change pm1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected or unmapped |
| cfg_mode | output | 32 | Mode word |
| cfg_div0 | output | 32 | Post-divider word 0 |
| cfg_div1 | output | 32 | Post-divider word 1 |
| cfg_pll0 | output | 32 | PLL0 control |
| cfg_pll1 | output | 32 | PLL1 control |
| cfg_gate | output | 32*N_GATE | Gate words, word g in bits [32g+31:32g] |
| cfg_pm0 | output | 32 | Power-management word 0 |
| cfg_pm1 | output | 32 | Power-management word 1 (not bus-visible) |

## Verification
The bench builds the block with its defaults, ADDR_W = 12 and N_GATE = 3. This puts every gate index, the constant at 18, pm0 at 23, the hidden pm1 at 24 and the top offset 0xffc within a single 4 KB window. With three gate words, a write to the first and the last gate word can be checked against an untouched middle one, which is visible both on the bus and on `cfg_gate`.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DW = 32;

    // Word indices on the bus (byte offset >> 2)
    localparam int IDX_MODE  = 0;
    localparam int IDX_DIV0  = 1;
    localparam int IDX_DIV1  = 2;
    localparam int IDX_PLL0  = 4;
    localparam int IDX_PLL1  = 6;
    localparam int IDX_GATE0 = 8;
    localparam int IDX_CONST = 18;
    localparam int IDX_PM0   = 23;

    // Writable storage slots
    localparam int SLOT_MODE  = 0;
    localparam int SLOT_DIV0  = 1;
    localparam int SLOT_DIV1  = 2;
    localparam int SLOT_PLL0  = 3;
    localparam int SLOT_PLL1  = 4;
    localparam int SLOT_GATE0 = 5;

    localparam logic [DW-1:0] MODE_RST   = 32'h074b0b7d;
    localparam logic [DW-1:0] DIV0_RST   = 32'hff870b48;
    localparam logic [DW-1:0] DIV1_RST   = 32'h49fcfe7f;
    localparam logic [DW-1:0] PLL0_RST   = 32'h04001800;
    localparam logic [DW-1:0] PLL1_RST   = 32'h04043001;
    localparam logic [DW-1:0] PM0_RST    = 32'h80209828;
    localparam logic [DW-1:0] PM1_RST    = 32'h00aa0000;
    localparam logic [DW-1:0] MODE_MASK  = 32'h3b6fdfff;
    localparam logic [DW-1:0] MODE_FORCE = 32'h00000020;
    localparam logic [DW-1:0] DIV0_MASK  = 32'hff9f3fff;
    localparam logic [DW-1:0] PLL_MASK   = 32'hbfff3fff;
    localparam logic [DW-1:0] CONST_VAL  = 32'h00004040;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;

    function automatic logic [DW-1:0] slot_reset(input int s);
        case (s)
            SLOT_MODE: return MODE_RST;
            SLOT_DIV0: return DIV0_RST;
            SLOT_DIV1: return DIV1_RST;
            SLOT_PLL0: return PLL0_RST;
            SLOT_PLL1: return PLL1_RST;
            default:   return '1;
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_mask(input int s);
        case (s)
            SLOT_MODE:            return MODE_MASK;
            SLOT_DIV0:            return DIV0_MASK;
            SLOT_PLL0, SLOT_PLL1: return PLL_MASK;
            default:              return '1;
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_force(input int s);
        return (s == SLOT_MODE) ? MODE_FORCE : '0;
    endfunction

endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_GATE = 3,
    localparam int IDX_W  = ADDR_W - 2,
    localparam int N_SLOT = SLOT_GATE0 + N_GATE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              aligned,
    output logic [N_SLOT-1:0] wr_sel,
    output logic              rd_hit
);

    always_comb begin
        idx     = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        wr_sel  = '0;
        wr_sel[SLOT_MODE] = (idx == IDX_W'(IDX_MODE));
        wr_sel[SLOT_DIV0] = (idx == IDX_W'(IDX_DIV0));
        wr_sel[SLOT_DIV1] = (idx == IDX_W'(IDX_DIV1));
        wr_sel[SLOT_PLL0] = (idx == IDX_W'(IDX_PLL0));
        wr_sel[SLOT_PLL1] = (idx == IDX_W'(IDX_PLL1));
        for (int g = 0; g < N_GATE; g++) begin
            wr_sel[SLOT_GATE0+g] = (idx == IDX_W'(IDX_GATE0 + g));
        end
        rd_hit = (|wr_sel) || (idx == IDX_W'(IDX_CONST)) || (idx == IDX_W'(IDX_PM0));
    end

endmodule

// File: rtl/clkctl_store.sv
module clkctl_store
    import clkctl_pkg::*;
#(
    parameter int N_GATE = 3,
    localparam int N_SLOT = SLOT_GATE0 + N_GATE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SLOT-1:0]    wr_en,
    input  logic [DW-1:0]        wdata,
    output logic [N_SLOT*DW-1:0] slots_q,
    output logic [DW-1:0]        pm0_q,
    output logic [DW-1:0]        pm1_q
);

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots_q[s*DW +: DW] <= slot_reset(s);
            end else if (wr_en[s]) begin
                slots_q[s*DW +: DW] <= (wdata & slot_mask(s)) | slot_force(s);
            end
        end
    end

    // Power-management words: loaded at reset, no bus write path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm0_q <= PM0_RST;
            pm1_q <= PM1_RST;
        end else begin
            pm0_q <= pm0_q;
            pm1_q <= pm1_q;
        end
    end

endmodule

// File: rtl/clkctl_rdmux.sv
module clkctl_rdmux
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_GATE = 3,
    localparam int IDX_W  = ADDR_W - 2,
    localparam int N_SLOT = SLOT_GATE0 + N_GATE
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [N_SLOT-1:0]    sel,
    input  logic [N_SLOT*DW-1:0] slots_q,
    input  logic [DW-1:0]        pm0_q,
    output logic [DW-1:0]        rd_data
);

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (sel[s]) rd_data = rd_data | slots_q[s*DW +: DW];
        end
        if (idx == IDX_W'(IDX_CONST)) rd_data = CONST_VAL;
        if (idx == IDX_W'(IDX_PM0))   rd_data = pm0_q;
    end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_GATE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_we,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    output logic [31:0]          cfg_mode,
    output logic [31:0]          cfg_div0,
    output logic [31:0]          cfg_div1,
    output logic [31:0]          cfg_pll0,
    output logic [31:0]          cfg_pll1,
    output logic [32*N_GATE-1:0] cfg_gate,
    output logic [31:0]          cfg_pm0,
    output logic [31:0]          cfg_pm1
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int N_SLOT = SLOT_GATE0 + N_GATE;

    bus_state_e            state_q, state_d;
    logic [IDX_W-1:0]      idx;
    logic                  aligned, rd_hit, accept, wr_ok;
    logic [N_SLOT-1:0]     wr_sel, wr_en;
    logic [N_SLOT*DW-1:0]  slots_q;
    logic [DW-1:0]         mux_data, rdata_q;
    logic                  err_q;

    clkctl_decode #(.ADDR_W(ADDR_W), .N_GATE(N_GATE)) u_decode (
        .addr    (req_addr),
        .idx     (idx),
        .aligned (aligned),
        .wr_sel  (wr_sel),
        .rd_hit  (rd_hit)
    );

    clkctl_store #(.N_GATE(N_GATE)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (req_wdata),
        .slots_q (slots_q),
        .pm0_q   (cfg_pm0),
        .pm1_q   (cfg_pm1)
    );

    clkctl_rdmux #(.ADDR_W(ADDR_W), .N_GATE(N_GATE)) u_rdmux (
        .idx     (idx),
        .sel     (wr_sel),
        .slots_q (slots_q),
        .pm0_q   (cfg_pm0),
        .rd_data (mux_data)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign wr_ok  = accept && req_we && aligned;
    assign wr_en  = wr_sel & {N_SLOT{wr_ok}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;   // accept
            ST_RESP: state_d = ST_IDLE;               // respond_done
        endcase
    end

    // Response outputs, captured on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            err_q   <= !aligned || (req_we ? !(|wr_sel) : !rd_hit);
            rdata_q <= (!req_we && aligned && rd_hit) ? mux_data : '0;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;

    assign cfg_mode = slots_q[SLOT_MODE*DW +: DW];
    assign cfg_div0 = slots_q[SLOT_DIV0*DW +: DW];
    assign cfg_div1 = slots_q[SLOT_DIV1*DW +: DW];
    assign cfg_pll0 = slots_q[SLOT_PLL0*DW +: DW];
    assign cfg_pll1 = slots_q[SLOT_PLL1*DW +: DW];
    assign cfg_gate = slots_q[N_SLOT*DW-1 : SLOT_GATE0*DW];

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_we,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [31:0]       cfg_mode,
    input logic [31:0]       cfg_div0,
    input logic [31:0]       cfg_pll0,
    input logic [31:0]       cfg_pll1,
    input logic [31:0]       cfg_pm1
);

    logic acc;
    assign acc = req_valid && req_ready;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_valid && !req_ready)); // R9
    AST_IDLE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R9
    AST_MODE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_we && req_addr == '0) |=> cfg_mode[5]); // R3
    AST_DIV0_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div0 & ~32'hff9f3fff) == 32'h0); // R4
    AST_PLL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_pll0 | cfg_pll1) & ~32'hbfff3fff) == 32'h0); // R4
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0)); // R7
    AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr[1:0] != 2'b00) |=> rsp_err); // R8
    AST_MISALIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr[1:0] != 2'b00) |=> ($stable(cfg_mode) && $stable(cfg_div0) && $stable(cfg_pll0))); // R8
    AST_PM1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_pm1)); // R10

endmodule

bind clkctl_regbank clkctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .cfg_mode  (cfg_mode),
    .cfg_div0  (cfg_div0),
    .cfg_pll0  (cfg_pll0),
    .cfg_pll1  (cfg_pll1),
    .cfg_pm1   (cfg_pm1)
);

// File: tb/clkctl_regbank_bench.sv
`timescale 1ns/1ps
module clkctl_regbank_bench;

    localparam int ADDR_W = 12;
    localparam int N_GATE = 3;
    localparam int NV     = 38;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic                 req_we = 1'b0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic                 rsp_err;
    logic [31:0]          cfg_mode, cfg_div0, cfg_div1, cfg_pll0, cfg_pll1, cfg_pm0, cfg_pm1;
    logic [32*N_GATE-1:0] cfg_gate;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    clkctl_regbank #(.ADDR_W(ADDR_W), .N_GATE(N_GATE)) u_clkctl_regbank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_mode(cfg_mode), .cfg_div0(cfg_div0), .cfg_div1(cfg_div1),
        .cfg_pll0(cfg_pll0), .cfg_pll1(cfg_pll1), .cfg_gate(cfg_gate),
        .cfg_pm0(cfg_pm0), .cfg_pm1(cfg_pm1)
    );

    // {req tag, we, addr, wdata, expected rdata, expected err}
    localparam logic [81:0] VEC [NV] = '{
        {4'd1,  1'b0, 12'h000, 32'h0,        32'h074b0b7d, 1'b0},
        {4'd1,  1'b0, 12'h004, 32'h0,        32'hff870b48, 1'b0},
        {4'd1,  1'b0, 12'h008, 32'h0,        32'h49fcfe7f, 1'b0},
        {4'd1,  1'b0, 12'h010, 32'h0,        32'h04001800, 1'b0},
        {4'd1,  1'b0, 12'h018, 32'h0,        32'h04043001, 1'b0},
        {4'd1,  1'b0, 12'h020, 32'h0,        32'hffffffff, 1'b0},
        {4'd1,  1'b0, 12'h024, 32'h0,        32'hffffffff, 1'b0},
        {4'd1,  1'b0, 12'h028, 32'h0,        32'hffffffff, 1'b0},
        {4'd6,  1'b0, 12'h048, 32'h0,        32'h00004040, 1'b0},
        {4'd1,  1'b0, 12'h05c, 32'h0,        32'h80209828, 1'b0},
        {4'd10, 1'b0, 12'h060, 32'h0,        32'h0,        1'b1},
        {4'd7,  1'b0, 12'h00c, 32'h0,        32'h0,        1'b1},
        {4'd3,  1'b1, 12'h000, 32'h0,        32'h0,        1'b0},
        {4'd3,  1'b0, 12'h000, 32'h0,        32'h00000020, 1'b0},
        {4'd3,  1'b1, 12'h000, 32'hffffffff, 32'h0,        1'b0},
        {4'd3,  1'b0, 12'h000, 32'h0,        32'h3b6fdfff, 1'b0},
        {4'd4,  1'b1, 12'h004, 32'hffffffff, 32'h0,        1'b0},
        {4'd4,  1'b0, 12'h004, 32'h0,        32'hff9f3fff, 1'b0},
        {4'd5,  1'b1, 12'h008, 32'h12345678, 32'h0,        1'b0},
        {4'd5,  1'b0, 12'h008, 32'h0,        32'h12345678, 1'b0},
        {4'd4,  1'b1, 12'h010, 32'hffffffff, 32'h0,        1'b0},
        {4'd4,  1'b0, 12'h010, 32'h0,        32'hbfff3fff, 1'b0},
        {4'd4,  1'b1, 12'h018, 32'h4000c000, 32'h0,        1'b0},
        {4'd4,  1'b0, 12'h018, 32'h0,        32'h0,        1'b0},
        {4'd5,  1'b1, 12'h020, 32'ha5a5a5a5, 32'h0,        1'b0},
        {4'd5,  1'b0, 12'h020, 32'h0,        32'ha5a5a5a5, 1'b0},
        {4'd5,  1'b1, 12'h028, 32'h00000001, 32'h0,        1'b0},
        {4'd5,  1'b0, 12'h028, 32'h0,        32'h00000001, 1'b0},
        {4'd6,  1'b1, 12'h048, 32'hdeadbeef, 32'h0,        1'b1},
        {4'd6,  1'b0, 12'h048, 32'h0,        32'h00004040, 1'b0},
        {4'd6,  1'b1, 12'h05c, 32'h0,        32'h0,        1'b1},
        {4'd6,  1'b0, 12'h05c, 32'h0,        32'h80209828, 1'b0},
        {4'd10, 1'b1, 12'h060, 32'h0,        32'h0,        1'b1},
        {4'd8,  1'b0, 12'h001, 32'h0,        32'h0,        1'b1},
        {4'd8,  1'b1, 12'h006, 32'h0,        32'h0,        1'b1},
        {4'd8,  1'b0, 12'h004, 32'h0,        32'hff9f3fff, 1'b0},
        {4'd7,  1'b1, 12'hffc, 32'hffffffff, 32'h0,        1'b1},
        {4'd2,  1'b0, 12'h024, 32'h0,        32'hffffffff, 1'b0}
    };

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one access; sample the response at the falling edge after acceptance
    task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        check("R9", "response strobe/ready", {94'd0, rsp_valid, req_ready}, {94'd0, 1'b1, 1'b0});
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state at the ports
        check("R9", "idle ready", {95'd0, req_ready}, {95'd0, 1'b1});
        check("R9", "idle no rsp", {95'd0, rsp_valid}, 96'd0);
        check("R1", "cfg_mode", {64'd0, cfg_mode}, {64'd0, 32'h074b0b7d});
        check("R1", "cfg_pll1", {64'd0, cfg_pll1}, {64'd0, 32'h04043001});
        check("R1", "cfg_pm0", {64'd0, cfg_pm0}, {64'd0, 32'h80209828});
        check("R1", "cfg_pm1", {64'd0, cfg_pm1}, {64'd0, 32'h00aa0000});
        check("R1", "cfg_gate", {0'd0, cfg_gate}, {96{1'b1}});

        for (int i = 0; i < NV; i++) begin
            logic [81:0] v;
            v = VEC[i];
            access(v[77], v[76:65], v[64:33], rd, er);
            check(tag(v[81:78]), $sformatf("vec %0d rdata", i), {64'd0, rd}, {64'd0, v[32:1]});
            check(tag(v[81:78]), $sformatf("vec %0d err", i), {95'd0, er}, {95'd0, v[0]});
        end

        // Parallel outputs after the table
        @(negedge clk);
        check("R5", "cfg_div1", {64'd0, cfg_div1}, {64'd0, 32'h12345678});
        check("R5", "cfg_gate", cfg_gate, {32'h00000001, 32'hffffffff, 32'ha5a5a5a5});
        check("R3", "cfg_mode", {64'd0, cfg_mode}, {64'd0, 32'h3b6fdfff});
        check("R4", "cfg_pll0", {64'd0, cfg_pll0}, {64'd0, 32'hbfff3fff});
        check("R6", "cfg_pm0 after write", {64'd0, cfg_pm0}, {64'd0, 32'h80209828});
        check("R10", "cfg_pm1 held", {64'd0, cfg_pm1}, {64'd0, 32'h00aa0000});

        // Mid-run reset restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "div0 after reset", {64'd0, cfg_div0}, {64'd0, 32'hff870b48});
        check("R1", "div1 after reset", {64'd0, cfg_div1}, {64'd0, 32'h49fcfe7f});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule